// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block executes a single raw NAND bus operation, built from up to six phases that software switches on or off. Software first loads the opcode pair, the address words, a byte count, a strobe timing word and a ready timeout through a small configuration write port. It then writes an operation word. That word selects the phases that run, the target chip and the number of address bytes.

The phases always run in the same order: first command, address bytes, second command, wait for ready, data out, data in. The block drives the command latch, the address latch, the write and read strobes, four active-low chip enables and an 8-bit data bus. Data sent during the data-out phase comes from a local byte buffer. Data captured during the data-in phase goes back into the same buffer, which software can read through a separate port.

A reset of the flash uses only the first-command and wait phases. A status poll uses the first-command and data-in phases. An identifier read adds a one-byte address phase ahead of the data-in phase.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, stat_idle is 1 and stat_tmo_err is 0. All four chip enables, WE# and RE# are high, and CLE and ALE are low. The timing word is 12'h375 (WE# low 5, RE# low 7, high 3). The byte count is 16.
- R2: Phases run in the fixed order first command, address, second command, wait, data out, data in. Their enables sit in bits 6, 5, 3, 2, 4 and 1 of the operation word. A phase that is disabled produces no strobe.
- R3: Chip select is bits 8:7 of the operation word. While an operation runs, only the selected nf_ce_n line is low. When idle, all four lines are high.
- R4: The command word (select 0) holds the first opcode in bits 7:0 and the second opcode in bits 15:8. Each opcode is driven with CLE high and ALE low on one WE# pulse.
- R5: The number of address bytes is bits 11:9 of the operation word, limited to 5. Bytes go out least significant first with ALE high. Bytes 0 to 3 come from the low address word (select 1), and byte 4 comes from bits 7:0 of the high address word (select 2).
- R6: The timing word (select 4) sets the WE# low width in bits 3:0, the RE# low width in bits 7:4 and the high width in bits 11:8, all in clock cycles. A field of 0 acts as 1.
- R7: CLE, ALE and the data bus hold steady across every WE# rising edge.
- R8: The wait phase ends after R/B# has been seen low and then high again. If the timeout (select 6) elapses first, stat_tmo_err is set and the operation ends. The flag holds until the next operation starts.
- R9: The data-in phase issues one RE# pulse per byte. The count comes from select 3, limited to the 16-entry buffer. Byte k is stored at buffer index k and can be read through buf_raddr/buf_rdata.
- R10: The data-out phase sends buffer entries 0 to count-1 in index order, one per WE# pulse, with nf_dq_oe high.
- R11: stat_idle is 1 when the sequencer is idle and 0 while an operation runs.
- R12: Writing the operation word (select 5) while an operation runs has no effect.
- R13: A write with select 7 stores cfg_wdata[7:0] at buffer index cfg_wdata[11:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| buf_raddr | input | 4 | Buffer read index |
| buf_rdata | output | 8 | Buffer read data |
| stat_idle | output | 1 | Sequencer idle |
| stat_tmo_err | output | 1 | Ready-wait timeout flag |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 4 | Chip enables, active low |
| nf_dq_out | output | 8 | Data bus output value |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_in | input | 8 | Data bus input value |
| nf_rb_n | input | 1 | Ready/busy from the flash, low when busy |

## Verification
The bench targets these corner cases:

- **Zero timing fields.** A design that counted a zero field as zero cycles would emit empty or runaway strobes.
- **Zero and oversized byte counts.** A wrong limit would produce stray RE# pulses or write past the buffer.
- **Address counts of 5, 6 and 7.** A design that took the fifth byte from the wrong word, or did not cap the count, would show wrong or extra ALE bytes.
- **Wait phase with no preceding command.** Here R/B# never drops, and a sequencer that did not time out would hang.
- **Second operation word written mid-operation.** A design that accepted it would add strobes to the running operation.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    PH_CMD1 = 3'd0,
    PH_ADDR = 3'd1,
    PH_CMD2 = 3'd2,
    PH_WAIT = 3'd3,
    PH_WDAT = 3'd4,
    PH_RDAT = 3'd5,
    PH_NONE = 3'd6
  } phase_e;

  localparam logic [2:0] SEL_CMD  = 3'd0;
  localparam logic [2:0] SEL_ALO  = 3'd1;
  localparam logic [2:0] SEL_AHI  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_TIM  = 3'd4;
  localparam logic [2:0] SEL_CTL  = 3'd5;
  localparam logic [2:0] SEL_TMO  = 3'd6;
  localparam logic [2:0] SEL_BUF  = 3'd7;

  // Phase-ordered enable mask: bit i enables phase_e value i.
  function automatic logic [5:0] phase_mask(input logic [11:0] ctl);
    return {ctl[1], ctl[4], ctl[2], ctl[3], ctl[5], ctl[6]};
  endfunction

  // First enabled phase at or after index 'from'.
  function automatic phase_e next_phase(input logic [5:0] m, input logic [2:0] from);
    phase_e r;
    r = PH_NONE;
    for (int i = 5; i >= 0; i--)
      if (i >= int'(from) && m[i]) r = phase_e'(i);
    return r;
  endfunction

  function automatic logic [3:0] strobe_cycles(input logic [3:0] n);
    return (n == 4'd0) ? 4'd1 : n;
  endfunction

  function automatic logic [2:0] addr_count(input logic [2:0] f);
    return (f > 3'd5) ? 3'd5 : f;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [2:0] i);
    return (i == 3'd4) ? hi[7:0] : lo[{i[1:0], 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TW      = 16,
  parameter int DEF_TMO = 1000,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [31:0]   wdata,
  output logic [15:0]   cmd,
  output logic [31:0]   alo,
  output logic [31:0]   ahi,
  output logic [CW-1:0] dcnt,
  output logic [11:0]   tim,
  output logic [TW-1:0] tmo,
  output logic [11:0]   ctl,
  output logic          start,
  output logic          bw_en,
  output logic [IW-1:0] bw_idx,
  output logic [7:0]    bw_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= '0;
      alo  <= '0;
      ahi  <= '0;
      dcnt <= CW'(DEPTH);
      tim  <= 12'h375;
      tmo  <= TW'(DEF_TMO);
    end else if (we) begin
      case (sel)
        SEL_CMD: cmd  <= wdata[15:0];
        SEL_ALO: alo  <= wdata;
        SEL_AHI: ahi  <= wdata;
        SEL_CNT: dcnt <= wdata[CW-1:0];
        SEL_TIM: tim  <= wdata[11:0];
        SEL_TMO: tmo  <= wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  assign ctl     = wdata[11:0];
  assign start   = we && (sel == SEL_CTL);
  assign bw_en   = we && (sel == SEL_BUF);
  assign bw_idx  = wdata[8 +: IW];
  assign bw_data = wdata[7:0];

endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_we,
  input  logic [IW-1:0] seq_idx,
  input  logic [7:0]    seq_wdata,
  output logic [7:0]    seq_rdata,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [7:0]    sw_wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (seq_we) begin
      mem[seq_idx] <= seq_wdata;
    end else if (sw_we) begin
      mem[sw_idx] <= sw_wdata;
    end
  end

  assign seq_rdata = mem[seq_idx];
  assign rd_data   = mem[rd_idx];

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW    = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1,
  localparam int XW = (CW > 3) ? CW : 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [11:0]   ctl,
  input  logic [15:0]   cmd,
  input  logic [31:0]   alo,
  input  logic [31:0]   ahi,
  input  logic [CW-1:0] dcnt,
  input  logic [11:0]   tim,
  input  logic [TW-1:0] tmo,
  input  logic          rb_n,
  input  logic [7:0]    dq_in,
  input  logic [7:0]    buf_rd,
  output logic [IW-1:0] buf_idx,
  output logic          buf_we,
  output logic [7:0]    buf_wd,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [3:0]    ce_n,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  output logic          busy,
  output logic          err
);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LOW, S_HIGH, S_WLO, S_WHI} st_e;

  st_e            st;
  phase_e         ph;
  logic [5:0]     mask;
  logic [1:0]     cs;
  logic [2:0]     ac;
  logic [3:0]     tc;
  logic [XW-1:0]  idx;
  logic [TW-1:0]  tw;
  logic [XW-1:0]  n_items;
  phase_e         first_ph, nxt_ph;
  logic [3:0]     low_len, hi_len;
  logic           in_xfer, is_cmd, tmo_hit;

  assign first_ph = next_phase(phase_mask(ctl), 3'd0);
  assign nxt_ph   = next_phase(mask, 3'(ph) + 3'd1);
  assign hi_len   = strobe_cycles(tim[11:8]);
  assign low_len  = (ph == PH_RDAT) ? strobe_cycles(tim[7:4]) : strobe_cycles(tim[3:0]);
  assign tmo_hit  = (tw == tmo);

  always_comb begin
    case (ph)
      PH_CMD1, PH_CMD2: n_items = XW'(1);
      PH_ADDR:          n_items = XW'(addr_count(ac));
      PH_WDAT, PH_RDAT: n_items = (dcnt > CW'(DEPTH)) ? XW'(DEPTH) : XW'(dcnt);
      default:          n_items = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_NONE; mask <= '0; cs <= '0; ac <= '0;
      tc <= '0; idx <= '0; tw <= '0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mask <= phase_mask(ctl);
          cs   <= ctl[8:7];
          ac   <= ctl[11:9];
          err  <= 1'b0;
          if (first_ph != PH_NONE) begin
            ph <= first_ph; st <= S_GAP; tc <= strobe_cycles(tim[11:8]); idx <= '0;
          end
        end
        S_GAP: begin
          if (tc > 4'd1) tc <= tc - 4'd1;
          else if (ph == PH_WAIT) begin st <= S_WLO; tw <= '0; end
          else if (n_items == '0) begin
            ph <= nxt_ph; idx <= '0; tc <= hi_len;
            st <= (nxt_ph == PH_NONE) ? S_IDLE : S_GAP;
          end else begin st <= S_LOW; tc <= low_len; end
        end
        S_LOW: begin
          if (tc > 4'd1) tc <= tc - 4'd1;
          else begin st <= S_HIGH; tc <= hi_len; end
        end
        S_HIGH: begin
          if (tc > 4'd1) tc <= tc - 4'd1;
          else if (idx + XW'(1) == n_items) begin
            ph <= nxt_ph; idx <= '0; tc <= hi_len;
            st <= (nxt_ph == PH_NONE) ? S_IDLE : S_GAP;
          end else begin idx <= idx + XW'(1); st <= S_LOW; tc <= low_len; end
        end
        S_WLO, S_WHI: begin
          if (tmo_hit) begin err <= 1'b1; st <= S_IDLE; ph <= PH_NONE; end
          else begin
            tw <= tw + TW'(1);
            if (st == S_WLO && !rb_n) st <= S_WHI;
            else if (st == S_WHI && rb_n) begin
              ph <= nxt_ph; idx <= '0; tc <= hi_len;
              st <= (nxt_ph == PH_NONE) ? S_IDLE : S_GAP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign in_xfer = (st == S_LOW) || (st == S_HIGH);
  assign is_cmd  = (ph == PH_CMD1) || (ph == PH_CMD2);
  assign cle     = (in_xfer || st == S_GAP) && is_cmd;
  assign ale     = (in_xfer || st == S_GAP) && (ph == PH_ADDR);
  assign we_n    = !(st == S_LOW && ph != PH_RDAT);
  assign re_n    = !(st == S_LOW && ph == PH_RDAT);
  assign ce_n    = busy ? ~(4'b0001 << cs) : 4'hF;
  assign dq_oe   = in_xfer && (is_cmd || ph == PH_ADDR || ph == PH_WDAT);
  assign buf_idx = idx[IW-1:0];
  assign buf_we  = (st == S_LOW) && (tc == 4'd1) && (ph == PH_RDAT);
  assign buf_wd  = dq_in;

  always_comb begin
    case (ph)
      PH_CMD1: dq_out = cmd[7:0];
      PH_CMD2: dq_out = cmd[15:8];
      PH_ADDR: dq_out = addr_byte(alo, ahi, idx[2:0]);
      PH_WDAT: dq_out = buf_rd;
      default: dq_out = 8'h00;
    endcase
  end

  // R3: at most one enable low, none when idle
  assert_ce_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n) && (busy || ce_n == 4'hF));
  // R4: command and address latches never together
  assert_latch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R6: write and read strobes never low together
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n) we_n || re_n);
  // R7: latch lines and bus steady at write strobe rise
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> $stable(cle) && $stable(ale) && $stable(dq_out));
  // R8: timeout flag holds until a new operation is accepted
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(start && !busy) |=> err);
  // R9: buffer captures only during a read strobe
  assert_capture_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !re_n);
  // R12: an operation word during a running operation changes nothing latched
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(mask) && $stable(cs) && $stable(ac));

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
  parameter int DEPTH   = 16,
  parameter int TW      = 16,
  parameter int DEF_TMO = 1000,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic [IW-1:0] buf_raddr,
  output logic [7:0]    buf_rdata,
  output logic          stat_idle,
  output logic          stat_tmo_err,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic [3:0]    nf_ce_n,
  output logic [7:0]    nf_dq_out,
  output logic          nf_dq_oe,
  input  logic [7:0]    nf_dq_in,
  input  logic          nf_rb_n
);

  logic [15:0]   cmd;
  logic [31:0]   alo, ahi;
  logic [CW-1:0] dcnt;
  logic [11:0]   tim, ctl;
  logic [TW-1:0] tmo;
  logic          start, bw_en, sq_we, busy;
  logic [IW-1:0] bw_idx, sq_idx;
  logic [7:0]    bw_data, sq_wd, sq_rd;

  nand_seq_regs #(.DEPTH(DEPTH), .TW(TW), .DEF_TMO(DEF_TMO)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .cmd(cmd), .alo(alo), .ahi(ahi), .dcnt(dcnt), .tim(tim), .tmo(tmo), .ctl(ctl),
    .start(start), .bw_en(bw_en), .bw_idx(bw_idx), .bw_data(bw_data));

  nand_seq_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .seq_we(sq_we), .seq_idx(sq_idx), .seq_wdata(sq_wd),
    .seq_rdata(sq_rd), .sw_we(bw_en), .sw_idx(bw_idx), .sw_wdata(bw_data),
    .rd_idx(buf_raddr), .rd_data(buf_rdata));

  nand_seq_fsm #(.DEPTH(DEPTH), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .cmd(cmd), .alo(alo), .ahi(ahi),
    .dcnt(dcnt), .tim(tim), .tmo(tmo), .rb_n(nf_rb_n), .dq_in(nf_dq_in), .buf_rd(sq_rd),
    .buf_idx(sq_idx), .buf_we(sq_we), .buf_wd(sq_wd), .cle(nf_cle), .ale(nf_ale),
    .we_n(nf_we_n), .re_n(nf_re_n), .ce_n(nf_ce_n), .dq_out(nf_dq_out), .dq_oe(nf_dq_oe),
    .busy(busy), .err(stat_tmo_err));

  assign stat_idle = !busy;

endmodule

// File: tb/nand_op_seq_bench.sv
module nand_op_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  buf_raddr = '0;
  logic [7:0]  buf_rdata;
  logic        stat_idle, stat_tmo_err;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [3:0]  nf_ce_n;
  logic [7:0]  nf_dq_out;
  logic [7:0]  nf_dq_in = '0;
  logic        nf_rb_n = 1'b1;

  always #4 clk = ~clk;

  nand_op_seq u_nand_op_seq (.*);

  int errors = 0, checks = 0;

  // model state
  logic [15:0] m_cmd = '0;
  logic [31:0] m_alo = '0, m_ahi = '0;
  logic [4:0]  m_cnt = 5'd16;
  logic [11:0] m_tim = 12'h375;
  logic [7:0]  mb [16];
  logic [7:0]  rd_seed = 8'h3C;

  // expectations
  logic [9:0]  x_ev [64];
  int          x_nev, x_nre;
  bit          x_to;
  logic [3:0]  exp_ce = 4'hF;

  // monitor records
  logic [9:0]  ev [64];
  int nev = 0, nre = 0, we_cnt = 0, re_cnt = 0, rd_k = 0, rb_tmr = 0;
  int we_bad = 0, re_bad = 0, ce_bad = 0, oe_bad = 0;
  bit prev_we = 1, prev_re = 1;

  function automatic logic [7:0] pat(input int k);
    return rd_seed + 8'(k * 29 + 5);
  endfunction

  function automatic int width_of(input logic [3:0] f);
    return (f == 0) ? 1 : int'(f);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!nf_we_n) begin
      we_cnt++;
      if (!nf_dq_oe) oe_bad++;
    end else if (!prev_we) begin
      if (nev < 64) ev[nev] = {nf_cle, nf_ale, nf_dq_out};
      nev++;
      if (we_cnt != width_of(m_tim[3:0])) we_bad++;
      if (nf_cle) rb_tmr = 200;
      we_cnt = 0;
    end
    if (!nf_re_n) re_cnt++;
    else if (!prev_re) begin
      nre++;
      if (re_cnt != width_of(m_tim[7:4])) re_bad++;
      re_cnt = 0;
      rd_k++;
      nf_dq_in = pat(rd_k);
    end
    if (!stat_idle && nf_ce_n !== exp_ce) ce_bad++;
    if (rb_tmr > 0) rb_tmr--;
    nf_rb_n = (rb_tmr == 0);
    prev_we = nf_we_n;
    prev_re = nf_re_n;
  end

  task automatic cfg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      3'd0: m_cmd = d[15:0];
      3'd1: m_alo = d;
      3'd2: m_ahi = d;
      3'd3: m_cnt = d[4:0];
      3'd4: m_tim = d[11:0];
      3'd7: mb[d[11:8]] = d[7:0];
      default: ;
    endcase
  endtask

  task automatic build_exp(input logic [11:0] c);
    int ac, n;
    n = (m_cnt > 16) ? 16 : int'(m_cnt);
    ac = (c[11:9] > 5) ? 5 : int'(c[11:9]);
    x_nev = 0; x_nre = 0; x_to = 0;
    if (c[6]) begin x_ev[x_nev] = {2'b10, m_cmd[7:0]}; x_nev++; end
    if (c[5]) for (int i = 0; i < ac; i++) begin
      x_ev[x_nev] = {2'b01, (i < 4) ? 8'(m_alo >> (8 * i)) : m_ahi[7:0]}; x_nev++;
    end
    if (c[3]) begin x_ev[x_nev] = {2'b10, m_cmd[15:8]}; x_nev++; end
    if (c[2] && !(c[6] || c[3])) x_to = 1;
    if (!x_to) begin
      if (c[4]) for (int i = 0; i < n; i++) begin x_ev[x_nev] = {2'b00, mb[i]}; x_nev++; end
      if (c[1]) begin
        x_nre = n;
        for (int i = 0; i < n; i++) mb[i] = pat(i);
      end
    end
  endtask

  task automatic run_op(input logic [11:0] c, input bit mid_write);
    @(posedge clk);
    nev = 0; nre = 0; rd_k = 0; nf_dq_in = pat(0);
    we_bad = 0; re_bad = 0; ce_bad = 0; oe_bad = 0;
    exp_ce = ~(4'b0001 << c[8:7]);
    build_exp(c);
    cfg(3'd5, {20'h0, c});
    if (c[6:1] != 0) chk(stat_idle == 1'b0, "R11 busy after start", stat_idle, 0);
    if (mid_write) cfg(3'd5, 32'h0000_027E);
    while (!stat_idle) @(negedge clk);
    while (!nf_rb_n) @(negedge clk);
    chk(nev == x_nev, "R2 write strobe count", nev, x_nev);
    for (int i = 0; i < x_nev && i < nev; i++)
      chk(ev[i] == x_ev[i], "R4/R5/R10 strobe byte and latches", ev[i], x_ev[i]);
    chk(nre == x_nre, "R9 read strobe count", nre, x_nre);
    chk(we_bad == 0 && re_bad == 0, "R6 strobe low widths", we_bad + re_bad, 0);
    chk(ce_bad == 0, "R3 chip enable during operation", ce_bad, 0);
    chk(oe_bad == 0, "R10 bus drive during write strobe", oe_bad, 0);
    chk(stat_tmo_err == x_to, "R8 timeout flag", stat_tmo_err, x_to);
    chk(nf_ce_n == 4'hF, "R3 enables idle", nf_ce_n, 4'hF);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); buf_raddr = 4'(i); #1;
      chk(buf_rdata == mb[i], "R9/R13 buffer content", buf_rdata, mb[i]);
    end
  endtask

  task automatic load_buf();
    for (int i = 0; i < 16; i++) cfg(3'd7, {20'h0, 4'(i), 8'($urandom)});
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mb[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stat_idle == 1 && stat_tmo_err == 0, "R1 idle and no error", {stat_idle, stat_tmo_err}, 2'b10);
    chk(nf_ce_n == 4'hF && nf_we_n && nf_re_n, "R1 strobes and enables high",
        {nf_ce_n, nf_we_n, nf_re_n}, 6'h3F);
    chk(!nf_cle && !nf_ale, "R1 latches low", {nf_cle, nf_ale}, 0);
    cfg(3'd6, 32'd600);
    // status-poll style, default timing and count (R1, R6)
    cfg(3'd0, 32'h0000_0070);
    run_op(12'h042, 0);
    // reset style with wait phase (R8), while busy try another word (R12)
    cfg(3'd0, 32'h0000_00FF);
    run_op(12'h044 | 12'h080, 1);
    @(negedge clk); @(negedge clk);
    chk(stat_idle == 1, "R12 stays idle after ignored word", stat_idle, 1);
    // identifier read: one address byte then default count
    cfg(3'd0, 32'h0000_0090); cfg(3'd1, 32'h0000_0000);
    run_op(12'h262 | 12'h180, 0);
    // five address bytes, field 7 clamps to 5 (R5)
    cfg(3'd1, 32'h4433_2211); cfg(3'd2, 32'h0000_0A55); cfg(3'd0, 32'h0000_3000);
    run_op(12'hE68, 0);
    // wait phase with no command: timeout (R8), then a clean op clears it
    cfg(3'd6, 32'd40);
    run_op(12'h004, 0);
    cfg(3'd6, 32'd600);
    run_op(12'h040, 0);
    // zero timing fields and zero count (R6, R9)
    cfg(3'd4, 32'h0000_0000); cfg(3'd3, 32'd0);
    run_op(12'h052, 0);
    // oversized count clamps to buffer size, data out then in (R10, R9)
    cfg(3'd3, 32'd25); load_buf();
    run_op(12'h012, 0);
    // random operations
    for (int t = 0; t < 40; t++) begin
      cfg(3'd4, 32'($urandom) & 32'hFFF);
      cfg(3'd3, 32'($urandom_range(0, 20)));
      cfg(3'd0, 32'($urandom) & 32'hFFFF);
      cfg(3'd1, $urandom);
      cfg(3'd2, $urandom);
      load_buf();
      rd_seed = 8'($urandom);
      run_op({3'($urandom), 2'($urandom), 6'($urandom), 1'b0}, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=busy expected=idle");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule